// File: doc/BRIEF.md
# 100BASE-X Transmit Symbol Coder

This block turns the nibble stream of a media-independent transmit interface into the serial symbol stream of a 100 Mb/s link. Each accepted nibble becomes a 5-bit code-group; frame boundaries are marked by start and end delimiter pairs, a transmit error turns the current data group into the halt symbol, and idle groups fill every gap between frames. The groups are shifted out one bit per symbol-rate enable, most significant bit first.

For copper links the coded bits are XORed with an 11-stage key stream and sent as a three-level MLT-3 line value. For fiber links, selected by a static mode input, the key stream is left out and the bits go out as NRZI. The block runs on one clock. `bit_en_i` marks each 125 Mb/s bit slot, and `txd_take_o` tells the nibble source in which cycle its inputs are taken.

Top module: `tx100_coder`

## Requirements
- R1: A data nibble n becomes the code-group (first transmitted bit on the left) 0:11110 1:01001 2:10100 3:10101 4:01010 5:01011 6:01110 7:01111 8:10010 9:10011 A:10110 B:10111 C:11010 D:11011 E:11100 F:11101.
- R2: A take with `txen_i` high and no frame in progress sends J (11000), and the next take sends K (10001) whatever the inputs are. Together they replace the first two nibbles of the frame.
- R3: The first take of a frame with `txen_i` low sends T (01101), and the next take sends R (00111) whatever the inputs are. A new frame may start at the take that follows R.
- R4: A data take with `txen_i` and `txer_i` both high sends H (00100) in place of the nibble.
- R5: With no frame in progress the idle group 11111 is sent. The group in flight after reset is idle.
- R6: Groups are sent most significant bit first, one bit per `bit_en_i` cycle. `txd_take_o` is high exactly on the `bit_en_i` cycle that carries the fifth bit of a group, and the inputs are sampled in that cycle.
- R7: In copper mode each line bit is the code bit XOR X[n], where X[n] = X[n-11] XOR X[n-9]. The key register advances on every `bit_en_i`, is seeded with all ones (X[-1]..X[-11] = 1) at reset and never holds all zeros.
- R8: In copper mode `mlt3_o` follows the cycle 0, +1, 0, -1, moving one step on a line bit of 1 and holding on a 0. The encoding is 01 = +1, 00 = 0, 11 = -1, and the level is 0 after reset.
- R9: In fiber mode the key stream is not applied, `nrzi_o` toggles on a code bit of 1 and holds on a 0, and `mlt3_o` stays 0. In copper mode `nrzi_o` holds its value.
- R10: `sym_en_o` is high in the cycle after each `bit_en_i` cycle and low otherwise. The line outputs change only in those cycles. After reset `mlt3_o`, `nrzi_o` and `sym_en_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Symbol-rate bit slot enable |
| fiber_i | input | 1 | 1 = fiber (NRZI, no key stream), 0 = copper; static outside reset |
| txd_i | input | 4 | Transmit nibble |
| txen_i | input | 1 | Frame in progress |
| txer_i | input | 1 | Transmit error, forces halt symbol |
| txd_take_o | output | 1 | Inputs taken in this cycle |
| sym_en_o | output | 1 | Line outputs updated at the last edge |
| mlt3_o | output | 2 | MLT-3 level, two's complement |
| nrzi_o | output | 1 | NRZI line bit |

## Verification
The embedded assertions watch, on every cycle, the K group that follows J and the R group that follows T, the take spacing and the MSB-first load, a key register that never reaches zero, MLT-3 never jumping between +1 and -1, and lines that stay still without a bit enable or in the unused mode. Whether the groups carry the right codes in the right frame positions, and whether the scrambled MLT-3 levels match the stated recursion bit for bit, can only be shown by the bench. It runs a behavioural model on every clock and NRZI-decodes a fiber frame back into groups, using idle runs, a frame carrying every nibble value, a halt, a one-nibble frame, back-to-back frames and gaps in the bit enable.

// File: rtl/tx100_pkg.sv
package tx100_pkg;
  localparam int NIB_W = 4;
  localparam int GRP_W = 5;

  typedef logic [GRP_W-1:0] grp_t;

  localparam grp_t CG_I = 5'b11111;
  localparam grp_t CG_J = 5'b11000;
  localparam grp_t CG_K = 5'b10001;
  localparam grp_t CG_T = 5'b01101;
  localparam grp_t CG_R = 5'b00111;
  localparam grp_t CG_H = 5'b00100;

  typedef enum logic [1:0] {FR_IDLE, FR_SEC_K, FR_DATA, FR_SEC_R} frame_st_e;

  function automatic grp_t nib_to_grp(input logic [NIB_W-1:0] n);
    unique case (n)
      4'h0: return 5'b11110;
      4'h1: return 5'b01001;
      4'h2: return 5'b10100;
      4'h3: return 5'b10101;
      4'h4: return 5'b01010;
      4'h5: return 5'b01011;
      4'h6: return 5'b01110;
      4'h7: return 5'b01111;
      4'h8: return 5'b10010;
      4'h9: return 5'b10011;
      4'hA: return 5'b10110;
      4'hB: return 5'b10111;
      4'hC: return 5'b11010;
      4'hD: return 5'b11011;
      4'hE: return 5'b11100;
      default: return 5'b11101;
    endcase
  endfunction
endpackage

// File: rtl/tx100_group_enc.sv
module tx100_group_enc
  import tx100_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic [NIB_W-1:0] txd_i,
  input  logic             txen_i,
  input  logic             txer_i,
  output grp_t             grp_o
);
  frame_st_e st_q, st_d;

  always_comb begin
    st_d  = st_q;
    grp_o = CG_I;
    unique case (st_q)
      FR_IDLE: if (txen_i) begin
        grp_o = CG_J;
        st_d  = FR_SEC_K;
      end
      FR_SEC_K: begin
        grp_o = CG_K;
        st_d  = FR_DATA;
      end
      FR_DATA: if (txen_i) begin
        grp_o = txer_i ? CG_H : nib_to_grp(txd_i);
      end else begin
        grp_o = CG_T;
        st_d  = FR_SEC_R;
      end
      default: begin
        grp_o = CG_R;
        st_d  = FR_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= FR_IDLE;
    else if (take_i) st_q <= st_d;

  AST_K_AFTER_J: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && grp_o == CG_J) |=> (grp_o == CG_K)); // R2
  AST_R_AFTER_T: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && grp_o == CG_T) |=> (grp_o == CG_R)); // R3
endmodule

// File: rtl/tx100_serializer.sv
module tx100_serializer #(
  parameter int GRP_W = 5,
  parameter logic [GRP_W-1:0] RST_GRP = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_en_i,
  input  logic [GRP_W-1:0] grp_i,
  output logic             take_o,
  output logic             bit_o
);
  localparam int SLOT_W = $clog2(GRP_W);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(GRP_W - 1);

  logic [SLOT_W-1:0] slot_q;
  logic [GRP_W-1:0]  sh_q;

  assign take_o = bit_en_i && (slot_q == LAST);
  assign bit_o  = sh_q[GRP_W-1];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      slot_q <= '0;
      sh_q   <= RST_GRP;
    end else if (bit_en_i) begin
      if (take_o) begin
        slot_q <= '0;
        sh_q   <= grp_i;
      end else begin
        slot_q <= slot_q + 1'b1;
        sh_q   <= {sh_q[GRP_W-2:0], 1'b0};
      end
    end

  AST_TAKE_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !take_o); // R6
  AST_MSB_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> (bit_o == $past(grp_i[GRP_W-1]))); // R6
endmodule

// File: rtl/tx100_scrambler.sv
module tx100_scrambler #(
  parameter int LFSR_W = 11,
  parameter int TAP    = 9,
  parameter logic [LFSR_W-1:0] SEED = '1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  output logic key_o
);
  logic [LFSR_W-1:0] lfsr_q;

  // lfsr_q[k] holds X[n-1-k]
  assign key_o = lfsr_q[LFSR_W-1] ^ lfsr_q[TAP-1];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) lfsr_q <= SEED;
    else if (adv_i) lfsr_q <= {lfsr_q[LFSR_W-2:0], key_o};

  AST_LFSR_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0); // R7
endmodule

// File: rtl/tx100_line_coder.sv
module tx100_line_coder (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_en_i,
  input  logic       fiber_i,
  input  logic       line_bit_i,
  output logic       sym_en_o,
  output logic [1:0] mlt3_o,
  output logic       nrzi_o
);
  logic [1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      phase_q  <= '0;
      nrzi_o   <= 1'b0;
      sym_en_o <= 1'b0;
    end else begin
      sym_en_o <= bit_en_i;
      if (fiber_i) begin
        phase_q <= '0;
        if (bit_en_i) nrzi_o <= nrzi_o ^ line_bit_i;
      end else if (bit_en_i) begin
        phase_q <= phase_q + {1'b0, line_bit_i};
      end
    end

  always_comb
    unique case (phase_q)
      2'd1:    mlt3_o = 2'b01;
      2'd3:    mlt3_o = 2'b11;
      default: mlt3_o = 2'b00;
    endcase

  AST_NO_JUMP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mlt3_o == 2'b11) |=> (mlt3_o != 2'b01)); // R8
  AST_NO_JUMP_DN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mlt3_o == 2'b01) |=> (mlt3_o != 2'b11)); // R8
  AST_FIBER_MLT3_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiber_i |=> (mlt3_o == 2'b00)); // R9
  AST_COPPER_NRZI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fiber_i |=> $stable(nrzi_o)); // R9
  AST_IDLE_SLOT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> ($stable(mlt3_o) && $stable(nrzi_o) && !sym_en_o)); // R10
endmodule

// File: rtl/tx100_coder.sv
module tx100_coder
  import tx100_pkg::*;
#(
  parameter int LFSR_W = 11,
  parameter int TAP    = 9,
  parameter logic [LFSR_W-1:0] SEED = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_en_i,
  input  logic             fiber_i,
  input  logic [NIB_W-1:0] txd_i,
  input  logic             txen_i,
  input  logic             txer_i,
  output logic             txd_take_o,
  output logic             sym_en_o,
  output logic [1:0]       mlt3_o,
  output logic             nrzi_o
);
  grp_t grp;
  logic code_bit, key, line_bit;

  tx100_group_enc u_enc (
    .clk_i, .rst_ni,
    .take_i(txd_take_o),
    .txd_i, .txen_i, .txer_i,
    .grp_o(grp)
  );

  tx100_serializer #(.GRP_W(GRP_W), .RST_GRP(CG_I)) u_ser (
    .clk_i, .rst_ni, .bit_en_i,
    .grp_i(grp),
    .take_o(txd_take_o),
    .bit_o(code_bit)
  );

  tx100_scrambler #(.LFSR_W(LFSR_W), .TAP(TAP), .SEED(SEED)) u_scr (
    .clk_i, .rst_ni,
    .adv_i(bit_en_i),
    .key_o(key)
  );

  assign line_bit = fiber_i ? code_bit : (code_bit ^ key);

  tx100_line_coder u_line (
    .clk_i, .rst_ni, .bit_en_i, .fiber_i,
    .line_bit_i(line_bit),
    .sym_en_o, .mlt3_o, .nrzi_o
  );
endmodule

// File: tb/tb_tx100_coder.sv
module tb_tx100_coder;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bit_en = 1'b0, fiber = 1'b0, txen = 1'b0, txer = 1'b0;
  logic [3:0] txd = '0;
  logic take, sym_en, nrzi;
  logic [1:0] mlt3;

  always #2 clk = ~clk;

  tx100_coder dut (
    .clk_i(clk), .rst_ni(rst_ni), .bit_en_i(bit_en), .fiber_i(fiber),
    .txd_i(txd), .txen_i(txen), .txer_i(txer),
    .txd_take_o(take), .sym_en_o(sym_en), .mlt3_o(mlt3), .nrzi_o(nrzi)
  );

  int checks = 0, failures = 0;
  bit done = 0, chk_on = 0, gap_mode = 0;
  int pat = 0;

  logic bq[$];
  logic kh[$];
  logic rx[$];
  int est, ph;
  logic exp_nrzi, exp_sym, exp_take, last_nrzi, took;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] data_code(input logic [3:0] n);
    logic [4:0] tbl [16] = '{5'h1E, 5'h09, 5'h14, 5'h15, 5'h0A, 5'h0B, 5'h0E, 5'h0F,
                             5'h12, 5'h13, 5'h16, 5'h17, 5'h1A, 5'h1B, 5'h1C, 5'h1D};
    return tbl[n];
  endfunction

  function automatic logic [4:0] model_group(input logic en, input logic [3:0] d, input logic er);
    logic [4:0] g;
    case (est)
      0: if (en) begin g = 5'b11000; est = 1; end else g = 5'b11111;
      1: begin g = 5'b10001; est = 2; end
      2: if (en) g = er ? 5'b00100 : data_code(d);
         else begin g = 5'b01101; est = 3; end
      default: begin g = 5'b00111; est = 0; end
    endcase
    return g;
  endfunction

  function automatic logic [1:0] lvl(input int p);
    return (p == 1) ? 2'b01 : (p == 3) ? 2'b11 : 2'b00;
  endfunction

  task automatic tick(input logic en, input logic [3:0] d, input logic er);
    logic b, k, lb;
    logic [4:0] g;
    @(negedge clk);
    if (chk_on) begin
      chk(mlt3 == (fiber ? 2'b00 : lvl(ph)), fiber ? "R9 mlt3" : "R7 R8 mlt3", mlt3, fiber ? 0 : lvl(ph));
      chk(nrzi == exp_nrzi, "R9 nrzi", nrzi, exp_nrzi);
      chk(sym_en == exp_sym, "R10 sym_en", sym_en, exp_sym);
      if (fiber && sym_en) begin
        rx.push_back(nrzi ^ last_nrzi);
        last_nrzi = nrzi;
      end
    end
    bit_en = gap_mode ? ((pat % 5) != 2) : 1'b1;
    pat++;
    txen = en; txd = d; txer = er;
    #1;
    took = 0;
    if (bit_en) begin
      exp_take = (bq.size() == 1);
      b = bq.pop_front();
      k = kh[kh.size()-11] ^ kh[kh.size()-9];
      kh.push_back(k);
      void'(kh.pop_front());
      lb = fiber ? b : (b ^ k);
      if (bq.size() == 0) begin
        g = model_group(en, d, er);
        for (int i = 4; i >= 0; i--) bq.push_back(g[i]);
        took = 1;
      end
      if (fiber) exp_nrzi = exp_nrzi ^ lb;
      else ph = (ph + int'(lb)) % 4;
      exp_sym = 1;
    end else begin
      exp_take = 0;
      exp_sym = 0;
    end
    chk(take == exp_take, "R6 take", take, exp_take);
  endtask

  task automatic nib(input logic en, input logic [3:0] d, input logic er);
    for (int i = 0; i < 20; i++) begin
      tick(en, d, er);
      if (took) break;
    end
  endtask

  task automatic do_reset(input logic fib);
    chk_on = 0;
    @(negedge clk);
    rst_ni = 0; bit_en = 0; fiber = fib; txen = 0; txer = 0;
    repeat (3) @(negedge clk);
    chk(mlt3 == 2'b00, "R10 reset mlt3", mlt3, 0);
    chk(nrzi == 1'b0, "R10 reset nrzi", nrzi, 0);
    chk(sym_en == 1'b0, "R10 reset sym_en", sym_en, 0);
    chk(take == 1'b0, "R10 reset take", take, 0);
    bq.delete(); kh.delete(); rx.delete();
    for (int i = 0; i < 5; i++) bq.push_back(1'b1);
    for (int i = 0; i < 11; i++) kh.push_back(1'b1);
    est = 0; ph = 0; exp_nrzi = 0; exp_sym = 0; last_nrzi = 0;
    rst_ni = 1;
    chk_on = 1;
  endtask

  task automatic frame(input int n, input int err_at);
    nib(1, 4'h5, 0);
    nib(1, 4'h5, 0);
    for (int i = 0; i < n; i++) nib(1, 4'(i), i == err_at);
    nib(0, 0, 0);
  endtask

  initial begin
    logic [4:0] exp_g [12] = '{5'b11111, 5'b11111, 5'b11111, 5'b11000, 5'b10001, 5'b10110,
                              5'b10101, 5'b00100, 5'b11110, 5'b01101, 5'b00111, 5'b11111};
    string tag_g [12] = '{"R5 reset idle", "R5 idle", "R5 idle", "R2 J", "R2 K", "R1 data A",
                         "R1 data 3", "R4 halt", "R1 data 0", "R3 T", "R3 R", "R5 idle after"};
    // copper
    do_reset(0);
    for (int i = 0; i < 60; i++) nib(0, 4'hF, 1);       // R5 idle, inputs ignored
    frame(16, -1);                                     // R1 every nibble
    for (int i = 0; i < 3; i++) nib(0, 0, 0);
    frame(4, 2);                                       // R4 halt
    nib(1, 4'h5, 0); nib(0, 0, 0); nib(0, 0, 0);       // R2 R3 one-nibble frame
    frame(3, -1); frame(3, -1);                        // R3 back-to-back
    gap_mode = 1;
    frame(10, 5);
    for (int i = 0; i < 30; i++) nib(0, 0, 0);
    gap_mode = 0;
    for (int i = 0; i < 450; i++) nib(0, 0, 0);        // R7 beyond key period
    // fiber, decoded back to groups
    do_reset(1);
    nib(0, 0, 0); nib(0, 0, 0);
    nib(1, 4'h5, 0); nib(1, 4'h5, 0);
    nib(1, 4'hA, 0); nib(1, 4'h3, 0); nib(1, 4'h7, 1); nib(1, 4'h0, 0);
    nib(0, 0, 0); nib(0, 0, 0); nib(0, 0, 0);
    for (int i = 0; i < 12; i++) tick(0, 0, 0);
    chk(rx.size() >= 60, "R6 fiber bit count", rx.size(), 60);
    if (rx.size() >= 60)
      for (int g = 0; g < 12; g++) begin
        logic [4:0] v;
        for (int b = 0; b < 5; b++) v[4-b] = rx[5*g+b];
        chk(v == exp_g[g], tag_g[g], v, exp_g[g]);
      end
    gap_mode = 1;
    frame(6, 1);
    gap_mode = 0;
    for (int i = 0; i < 10; i++) nib(0, 0, 0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule